// File: doc/BRIEF.md
# GPIO Pad Register Bank

This block is the register file and pad-control core of a general-purpose I/O controller for up to 95 pins. A host reaches it over a plain 32-bit register bus with separate write and read strobes and a shared word address. Read data is registered and appears one cycle after the read strobe. The bank holds two kinds of storage. Banked bitmap registers give one bit per pin, packed 32 pins to a word. Two configuration words per pin are laid out on an 8-byte stride.

From this storage the block drives each pad's output level and output enable. It also exports a 2-bit pull select and a 2-bit function select per pin to the pad ring. The pad input goes through a two-flop synchronizer and is reported in the first configuration word, unless input sensing is switched off for that pin. Interrupt detection lives in a neighbouring block. That block reads the trigger fields and the status and enable bitmaps held here, so their offsets and bit positions are fixed.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every first config word reads 0x00000004 (input, native function, output level 0), every second config word reads 0x00000004 (sensing off, no pull), every bitmap word reads 0, and pad_oe, pad_out, pad_pull and pad_func are all 0.
- R2: The four bitmap registers sit at bases 0x00 (ownership), 0x10 (routing), 0x80 (status) and 0x90 (enable), with pin p in bit p%32 of the word at base+4*(p/32). They are read/write, and bits for pins at or above NPINS always read 0. The global select word at 0x7C keeps all 32 bits.
- R3: Pin p's first config word is at 0x100+8p and its second at 0x104+8p. In the first word, bits 31 (output level), 4 (level trigger), 3 (invert), 2 (direction, 1 = input) and 1:0 (use select, 1 = GPIO) read back as written. In the second word, bits 2 (sense disable) and 1:0 (pull: 0 none, 1 down, 2 up) read back as written. All other bits read 0, except bit 30 of the first word.
- R4: Bit 30 of the first config word reports the pad input through two flops. After pad_in changes, a read whose strobe is sampled on the second following clock edge still returns the old level, and a read on any later edge returns the new one.
- R5: While a pin's sense-disable bit is 1, its bit 30 reads 0 whatever the pad does. Writes to bit 30 are ignored.
- R6: pad_oe[p] is 1 only when pin p's use select is 1 and its direction bit is 0. pad_out[p] follows bit 31 of its first config word.
- R7: pad_func[2p+1:2p] equals pin p's use select, and pad_pull[2p+1:2p] equals its pull field.
- R8: Reads of unmapped or misaligned offsets, and of config words for pins at or above NPINS, return 0. Writes to them change no register.
- R9: bus_rdata changes only on the clock edge that samples bus_rd_en, and holds its value in cycles without a read.
- R10: When a read and a write to the same address fall on the same edge, the read returns the content before the write, and the written value is visible to the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables |
| pad_pull | output | 2*NPINS | Pull select, 2 bits per pin |
| pad_func | output | 2*NPINS | Function select, 2 bits per pin |

## Verification
Two events can share one clock edge. The first is a bus read and a bus write to the same word. The bench issues both strobes together and expects the pre-write content, then confirms the new value with a second read. The second is a pad input change travelling through the synchronizer while a config read samples it. The bench changes pad_in on a falling edge and reads at once, which must give the old level two edges later. A read on the next edge must give the new level, and this is checked against every pin under sensing both on and off.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned CFG_BASE   = 32'h100;
  localparam int unsigned CFG_STRIDE = 8;
  localparam int unsigned GSEL_OFF   = 32'h7C;
  localparam int unsigned NUM_MAPS   = 4;

  localparam int unsigned B_OUT  = 31;
  localparam int unsigned B_LVL  = 30;
  localparam int unsigned B_TRIG = 4;
  localparam int unsigned B_INV  = 3;
  localparam int unsigned B_DIR  = 2;
  localparam int unsigned B_DIS  = 2;

  localparam logic [1:0] USE_NATIVE = 2'd0;
  localparam logic [1:0] USE_GPIO   = 2'd1;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_MAP,
    RG_GSEL,
    RG_CFG1,
    RG_CFG2
  } region_e;

  typedef struct packed {
    region_e     region;
    logic [1:0]  map;
    logic [15:0] idx;
  } hit_t;

  // Byte base of bitmap register k: ownership, routing, status, enable.
  function automatic int unsigned map_base(input int unsigned k);
    case (k)
      0:       return 32'h00;
      1:       return 32'h10;
      2:       return 32'h80;
      default: return 32'h90;
    endcase
  endfunction

  // Bits of bitmap word w that belong to existing pins.
  function automatic logic [WORD_W-1:0] live_mask(input int unsigned w,
                                                  input int unsigned npins);
    logic [WORD_W-1:0] m;
    for (int unsigned b = 0; b < WORD_W; b++)
      m[b] = ((w * WORD_W + b) < npins);
    return m;
  endfunction

  // Address decode: bitmaps and global word below CFG_BASE, pin words above.
  function automatic hit_t decode_addr(input logic [31:0] a,
                                       input int unsigned npins,
                                       input int unsigned nwords);
    hit_t h;
    int unsigned ai;
    ai = a;
    h.region = RG_NONE;
    h.map    = 2'd0;
    h.idx    = 16'd0;
    if (a[1:0] == 2'b00) begin
      if (ai >= CFG_BASE) begin
        if (((ai - CFG_BASE) / CFG_STRIDE) < npins) begin
          h.region = a[2] ? RG_CFG2 : RG_CFG1;
          h.idx    = 16'((ai - CFG_BASE) / CFG_STRIDE);
        end
      end else if (ai == GSEL_OFF) begin
        h.region = RG_GSEL;
      end else begin
        for (int unsigned k = 0; k < NUM_MAPS; k++) begin
          if (ai >= map_base(k) && ai < map_base(k) + nwords * 4) begin
            h.region = RG_MAP;
            h.map    = 2'(k);
            h.idx    = 16'((ai - map_base(k)) / 4);
          end
        end
      end
    end
    return h;
  endfunction

endpackage

// File: rtl/gpb_addr_dec.sv
module gpb_addr_dec
  import gpb_pkg::*;
#(
  parameter int unsigned NPINS  = 95,
  parameter int unsigned NWORDS = 3,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit
);
  assign hit = decode_addr(32'(addr), NPINS, NWORDS);
endmodule

// File: rtl/gpb_bitmap_bank.sv
module gpb_bitmap_bank
  import gpb_pkg::*;
#(
  parameter int unsigned NPINS  = 95,
  parameter int unsigned NWORDS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [15:0]              widx,
  input  logic [WORD_W-1:0]        wdata,
  output logic [NWORDS*WORD_W-1:0] bits
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [WORD_W-1:0] LIVE = live_mask(w, NPINS);
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        word_q <= '0;
      else if (we && widx == 16'(w))     word_q <= wdata & LIVE;
    end
    assign bits[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/gpb_in_sync.sv
module gpb_in_sync #(
  parameter int unsigned WIDTH  = 95,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else             chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpb_pin_cfg.sv
module gpb_pin_cfg
  import gpb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_a,
  input  logic              we_b,
  input  logic              wd_out,
  input  logic [4:0]        wd_a_low,
  input  logic [2:0]        wd_b_low,
  input  logic              level_in,
  output logic [WORD_W-1:0] word_a,
  output logic [WORD_W-1:0] word_b,
  output logic              pad_out,
  output logic              pad_oe,
  output logic [1:0]        pull,
  output logic [1:0]        func,
  output logic              sense_off
);
  logic       out_q, trig_q, inv_q, dir_q, dis_q;
  logic [1:0] use_q, pull_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      trig_q <= 1'b0;
      inv_q  <= 1'b0;
      dir_q  <= 1'b1;
      use_q  <= USE_NATIVE;
    end else if (we_a) begin
      out_q  <= wd_out;
      trig_q <= wd_a_low[B_TRIG];
      inv_q  <= wd_a_low[B_INV];
      dir_q  <= wd_a_low[B_DIR];
      use_q  <= wd_a_low[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= 1'b1;
      pull_q <= 2'd0;
    end else if (we_b) begin
      dis_q  <= wd_b_low[B_DIS];
      pull_q <= wd_b_low[1:0];
    end
  end

  logic lvl_seen;
  assign lvl_seen  = level_in & ~dis_q;
  assign word_a    = {out_q, lvl_seen, 25'd0, trig_q, inv_q, dir_q, use_q};
  assign word_b    = {29'd0, dis_q, pull_q};
  assign pad_out   = out_q;
  assign pad_oe    = (use_q == USE_GPIO) && !dir_q;
  assign pull      = pull_q;
  assign func      = use_q;
  assign sense_off = dis_q;

  assert_oe_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_oe) |-> $past(we_a));

  assert_func_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(func) |-> $past(we_a));

  assert_pull_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull) |-> $past(we_b));
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpb_pkg::*;
#(
  parameter int unsigned NPINS  = 95,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NPINS-1:0]    pad_in,
  output logic [NPINS-1:0]    pad_out,
  output logic [NPINS-1:0]    pad_oe,
  output logic [2*NPINS-1:0]  pad_pull,
  output logic [2*NPINS-1:0]  pad_func
);
  localparam int unsigned NWORDS = (NPINS + WORD_W - 1) / WORD_W;
  localparam logic [WORD_W-1:0] TAIL_LIVE = live_mask(NWORDS - 1, NPINS);

  hit_t hit;
  gpb_addr_dec #(.NPINS(NPINS), .NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  // Bitmap registers
  logic [NWORDS*WORD_W-1:0] map_bits [NUM_MAPS];
  for (genvar k = 0; k < NUM_MAPS; k++) begin : g_map
    logic map_we;
    assign map_we = bus_wr_en && hit.region == RG_MAP && hit.map == 2'(k);
    gpb_bitmap_bank #(.NPINS(NPINS), .NWORDS(NWORDS)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (map_we),
      .widx  (hit.idx),
      .wdata (bus_wdata),
      .bits  (map_bits[k])
    );
  end

  logic [WORD_W-1:0] gsel_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   gsel_q <= '0;
    else if (bus_wr_en && hit.region == RG_GSEL)  gsel_q <= bus_wdata;
  end

  // Input synchronizer
  logic [NPINS-1:0] pad_sync;
  gpb_in_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  // Per-pin configuration
  logic [WORD_W-1:0] cfg_a [NPINS];
  logic [WORD_W-1:0] cfg_b [NPINS];
  logic [NPINS-1:0]  sense_off;
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic we_a, we_b;
    assign we_a = bus_wr_en && hit.region == RG_CFG1 && hit.idx == 16'(p);
    assign we_b = bus_wr_en && hit.region == RG_CFG2 && hit.idx == 16'(p);
    gpb_pin_cfg u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_a      (we_a),
      .we_b      (we_b),
      .wd_out    (bus_wdata[B_OUT]),
      .wd_a_low  (bus_wdata[4:0]),
      .wd_b_low  (bus_wdata[2:0]),
      .level_in  (pad_sync[p]),
      .word_a    (cfg_a[p]),
      .word_b    (cfg_b[p]),
      .pad_out   (pad_out[p]),
      .pad_oe    (pad_oe[p]),
      .pull      (pad_pull[2*p +: 2]),
      .func      (pad_func[2*p +: 2]),
      .sense_off (sense_off[p])
    );
  end

  // Read mux
  logic [WORD_W-1:0] rd_word;
  logic              sel_sense_off;
  always_comb begin
    rd_word       = '0;
    sel_sense_off = 1'b0;
    unique case (hit.region)
      RG_MAP: begin
        for (int unsigned k = 0; k < NUM_MAPS; k++)
          for (int unsigned w = 0; w < NWORDS; w++)
            if (hit.map == 2'(k) && hit.idx == 16'(w))
              rd_word = map_bits[k][w*WORD_W +: WORD_W];
      end
      RG_GSEL: rd_word = gsel_q;
      RG_CFG1: begin
        for (int unsigned p = 0; p < NPINS; p++)
          if (hit.idx == 16'(p)) begin
            rd_word       = cfg_a[p];
            sel_sense_off = sense_off[p];
          end
      end
      RG_CFG2: begin
        for (int unsigned p = 0; p < NPINS; p++)
          if (hit.idx == 16'(p)) rd_word = cfg_b[p];
      end
      default: rd_word = '0;
    endcase
  end

  // Named events for the assertions
  logic rd_none_q, rd_lvl_off_q, rd_tail_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata    <= '0;
      rd_none_q    <= 1'b0;
      rd_lvl_off_q <= 1'b0;
      rd_tail_q    <= 1'b0;
    end else begin
      if (bus_rd_en) bus_rdata <= rd_word;
      rd_none_q    <= bus_rd_en && hit.region == RG_NONE;
      rd_lvl_off_q <= bus_rd_en && hit.region == RG_CFG1 && sel_sense_off;
      rd_tail_q    <= bus_rd_en && hit.region == RG_MAP && hit.idx == 16'(NWORDS - 1);
    end
  end

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_none_q |-> bus_rdata == 32'd0);

  assert_sense_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lvl_off_q |-> bus_rdata[B_LVL] == 1'b0);

  assert_tail_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_tail_q |-> (bus_rdata & ~TAIL_LIVE) == 32'd0);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd_en) |-> $stable(bus_rdata));
endmodule

// File: tb/tb_gpio_pad_bank.sv
module tb_gpio_pad_bank;
  localparam int NP = 95;
  localparam int NW = 3;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [11:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NP-1:0]     pad_in = '0;
  logic [NP-1:0]     pad_out, pad_oe;
  logic [2*NP-1:0]   pad_pull, pad_func;

  gpio_pad_bank #(.NPINS(NP), .ADDR_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull(pad_pull), .pad_func(pad_func)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference model
  logic [31:0] m_a [NP];
  logic [31:0] m_b [NP];
  logic [31:0] m_map [4][NW];
  logic [31:0] m_gsel;
  int mbase [4] = '{0, 16, 128, 144};

  function automatic logic [11:0] a_cfg(input int p, input int second);
    return 12'(256 + p * 8 + second * 4);
  endfunction
  function automatic logic [31:0] pin_mask(input int w);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (w * 32 + b) < NP;
    return m;
  endfunction
  function automatic logic [31:0] exp_a(input int p);
    logic lvl;
    lvl = m_b[p][2] ? 1'b0 : pad_in[p];
    return (m_a[p] & 32'h8000_001F) | (32'(lvl) << 30);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_rw(input logic [11:0] a, input logic [31:0] wd, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_wr_en = 1'b1; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_rd_en = 1'b0; bus_wr_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check_pads(input string req);
    for (int p = 0; p < NP; p++) begin
      check(req, 32'(pad_oe[p]), 32'((m_a[p][1:0] == 2'd1) && !m_a[p][2]));
      check(req, 32'(pad_out[p]), 32'(m_a[p][31]));
      check(req, 32'(pad_func[2*p +: 2]), 32'(m_a[p][1:0]));
      check(req, 32'(pad_pull[2*p +: 2]), 32'(m_b[p][1:0]));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r, d;
    for (int p = 0; p < NP; p++) begin m_a[p] = 32'h4; m_b[p] = 32'h4; end
    for (int k = 0; k < 4; k++) for (int w = 0; w < NW; w++) m_map[k][w] = '0;
    m_gsel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int p = 0; p < NP; p++) begin
      bus_read(a_cfg(p, 0), r); check("R1", r, 32'h4);
      bus_read(a_cfg(p, 1), r); check("R1", r, 32'h4);
    end
    for (int k = 0; k < 4; k++)
      for (int w = 0; w < NW; w++) begin
        bus_read(12'(mbase[k] + 4*w), r); check("R1", r, 32'h0);
      end
    bus_read(12'h7C, r); check("R1", r, 32'h0);
    check("R1", 32'(|pad_oe), 0);
    check("R1", 32'(|pad_out), 0);
    check("R1", 32'(|pad_func), 0);
    check("R1", 32'(|pad_pull), 0);

    // R3, R6, R7: per-pin config sweep, all use/direction combinations
    for (int p = 0; p < NP; p++) begin
      d = (32'h9E37_79B9 * 32'(p + 1)) ^ 32'h5A5A_0000;
      d[1:0] = 2'(p % 4);
      d[2] = ((p / 4) % 2) == 1;
      m_a[p] = d;
      bus_write(a_cfg(p, 0), d);
      d = 32'hFFFF_FFF8 | 32'(p % 3);
      d[2] = (p % 5) != 0;
      m_b[p] = d;
      bus_write(a_cfg(p, 1), d);
    end
    for (int p = 0; p < NP; p++) begin
      bus_read(a_cfg(p, 0), r); check("R3", r, exp_a(p));
      bus_read(a_cfg(p, 1), r); check("R3", r, m_b[p] & 32'h7);
    end
    check_pads("R6/R7");

    // R2: bitmap words, tail masking and global word
    for (int k = 0; k < 4; k++)
      for (int w = 0; w < NW; w++) begin
        bus_write(12'(mbase[k] + 4*w), 32'hFFFF_FFFF);
        bus_read(12'(mbase[k] + 4*w), r); check("R2", r, pin_mask(w));
      end
    for (int k = 0; k < 4; k++)
      for (int w = 0; w < NW; w++) begin
        d = 32'h1234_5679 * 32'(k * NW + w + 3);
        m_map[k][w] = d & pin_mask(w);
        bus_write(12'(mbase[k] + 4*w), d);
      end
    for (int k = 0; k < 4; k++)
      for (int w = 0; w < NW; w++) begin
        bus_read(12'(mbase[k] + 4*w), r); check("R2", r, m_map[k][w]);
      end
    m_gsel = 32'hDEAD_BEEF;
    bus_write(12'h7C, m_gsel);
    bus_read(12'h7C, r); check("R2", r, m_gsel);

    // R4: two-flop input path, all pins sensing
    for (int p = 0; p < NP; p++) begin
      m_b[p] = 32'(p % 3);
      bus_write(a_cfg(p, 1), m_b[p]);
    end
    @(negedge clk);
    for (int p = 0; p < NP; p++) pad_in[p] = ((p * 7) % 3) == 0;
    bus_read(a_cfg(0, 0), r);
    check("R4 early", r, m_a[0] & 32'h8000_001F);
    bus_read(a_cfg(0, 0), r);
    check("R4 late", r, exp_a(0));
    for (int p = 0; p < NP; p++) begin
      bus_read(a_cfg(p, 0), r); check("R4", r, exp_a(p));
    end
    @(negedge clk);
    pad_in = ~pad_in;
    repeat (3) @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      bus_read(a_cfg(p, 0), r); check("R4", r, exp_a(p));
    end

    // R5: sensing off on even pins, bit 30 writes ignored
    @(negedge clk);
    pad_in = '1;
    for (int p = 0; p < NP; p += 2) begin
      m_b[p] = 32'h4 | 32'(p % 3);
      bus_write(a_cfg(p, 1), m_b[p]);
    end
    for (int p = 0; p < NP; p++) begin
      bus_read(a_cfg(p, 0), r); check("R5", r, exp_a(p));
    end
    bus_write(a_cfg(3, 0), m_a[3] & ~32'h4000_0000);
    bus_read(a_cfg(3, 0), r); check("R5 write ignored", r, exp_a(3));
    bus_write(a_cfg(4, 0), m_a[4] | 32'h4000_0000);
    bus_read(a_cfg(4, 0), r); check("R5 write ignored", r, exp_a(4));

    // R8: unmapped, misaligned and out-of-range pins
    begin
      logic [11:0] holes [9] = '{12'h00C, 12'h020, 12'h078, 12'h08C,
                                 12'h0A0, 12'h0FC, 12'h3F8, 12'h3FC, 12'h101};
      for (int i = 0; i < 9; i++) begin
        bus_write(holes[i], 32'hFFFF_FFFF);
        bus_read(holes[i], r); check("R8", r, 32'h0);
      end
      bus_read(12'hFF8, r); check("R8", r, 32'h0);
    end
    for (int k = 0; k < 4; k++)
      for (int w = 0; w < NW; w++) begin
        bus_read(12'(mbase[k] + 4*w), r); check("R8 no side effect", r, m_map[k][w]);
      end
    bus_read(12'h7C, r);         check("R8 no side effect", r, m_gsel);
    bus_read(a_cfg(0, 0), r);    check("R8 no side effect", r, exp_a(0));
    bus_read(a_cfg(NP-1, 0), r); check("R8 no side effect", r, exp_a(NP-1));
    bus_read(a_cfg(NP-1, 1), r); check("R8 no side effect", r, m_b[NP-1] & 32'h7);
    check_pads("R8 pads");

    // R9: read data holds across idle cycles and writes
    bus_read(a_cfg(5, 1), r);
    bus_write(a_cfg(5, 1), 32'h2);
    repeat (4) @(negedge clk);
    check("R9", bus_rdata, r);
    m_b[5] = 32'h2;

    // R10: simultaneous read and write to one word
    d = m_map[3][1] ^ 32'h0F0F_0F0F;
    bus_rw(12'(mbase[3] + 4), d, r);
    check("R10 old", r, m_map[3][1]);
    m_map[3][1] = d & pin_mask(1);
    bus_read(12'(mbase[3] + 4), r); check("R10 new", r, m_map[3][1]);
    d = 32'h8000_0001;
    bus_rw(a_cfg(7, 0), d, r);
    check("R10 old", r, exp_a(7));
    m_a[7] = d;
    bus_read(a_cfg(7, 0), r); check("R10 new", r, exp_a(7));
    check("R6", 32'(pad_oe[7]), 1);
    check("R6", 32'(pad_out[7]), 1);

    finish_run();
  end
endmodule